// File: doc/BRIEF.md
# Reset Qualifier and Boot Sequencer

This block turns the raw, active-low external reset pin into a clean internal reset and controls when the processor starts executing. A low level on the pin counts as a reset only if it lasts at least sixteen reference-clock cycles. Any shorter dip is discarded. A qualified reset, or the chip-level power-on reset, raises a one-cycle strobe that tells the register file to return every register to its power-on value. The processor is held while the pin stays low. After the pin is released, the block waits a programmable delay. It then issues the first instruction fetch at 0xFF00, followed by the fetch at 0xE000, which is the target of the jump stored at 0xFF00 and the start of the ROM region.

Two smaller duties sit beside the main sequence. A USB bus reset does not disturb the processor. It makes the block emit two clear strobes, one addressed at 0xC090 and one at 0xC0B0, and every other register is left alone. During a bounded window at the start of boot code, the block drives output-enables for GPIO bits 24..19 and 15..8 so that those pins act as test-mode outputs.

The processor is modelled only as a hold level plus fetch strobe and address. The register file is modelled only as a full-reset strobe and an addressed clear strobe.

Top module: `boot_reset_seq`

## Requirements
- R1: A low level on `rst_pin_ni` that lasts fewer than MIN_LOW_CYC (16) consecutive clock cycles has no effect: no `full_rst_o`, no hold, no fetch. A high cycle in the middle of a low level restarts the count.
- R2: A low level of MIN_LOW_CYC or more cycles raises `full_rst_o` for exactly one cycle, with `cpu_hold_o` high and `gpio_test_oe_o` zero in that cycle. `rst_ni` low also forces `full_rst_o`, and it stays high for the first cycle after release.
- R3: The first fetch (`fetch_valid_o` with address 0xFF00) is seen BOOT_DLY_CYC cycles after `rst_ni` is released, or BOOT_DLY_CYC+4 cycles after the pin returns high (two synchronizer stages, qualifier clear, hold exit). `cpu_hold_o` is high until then.
- R4: A boot issues exactly two consecutive fetch cycles, with address 0xFF00 and then 0xE000. After them `cpu_hold_o` and `fetch_valid_o` stay low.
- R5: A one-cycle pulse on `usb_reset_i` gives `usb_clr_o` on the next two cycles, with `usb_clr_addr_o` at 0xC090 and then 0xC0B0. It gives no `full_rst_o` and no change of `cpu_hold_o`, `fetch_valid_o` or `gpio_test_oe_o`.
- R6: A full reset always takes priority over the USB clear. If a qualified reset or power-on reset occurs in the same cycle as `usb_reset_i`, or during the two clear cycles, no further `usb_clr_o` follows. `usb_clr_o` is never high together with `full_rst_o`.
- R7: `gpio_test_oe_o` equals 0x01F8FF00 (bits 24..19 and 15..8 set) for exactly GPIO_WIN_CYC cycles, starting in the 0xE000 fetch cycle. Outside that window it is zero.
- R8: While `rst_ni` is low: `full_rst_o`=1, `cpu_hold_o`=1, `fetch_valid_o`=0, `usb_clr_o`=0 and `gpio_test_oe_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 12 MHz reference clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_ni | input | 1 | External reset pin, active low, asynchronous to clk_i |
| usb_reset_i | input | 1 | One-cycle USB bus reset request |
| full_rst_o | output | 1 | Full register reset strobe |
| usb_clr_o | output | 1 | Addressed register clear strobe |
| usb_clr_addr_o | output | 16 | Address of the register being cleared |
| cpu_hold_o | output | 1 | Processor held in reset |
| fetch_valid_o | output | 1 | Boot fetch strobe |
| fetch_addr_o | output | 16 | Boot fetch address |
| gpio_test_oe_o | output | GPIO_W | Test-mode output enables for GPIO |

## Verification
A qualifier count that is off by one shows up as a 15-cycle pulse that resets the chip, or a 16-cycle pulse that does not. Either is visible at `full_rst_o` about eighteen cycles after the pin falls. A delay or window counter that loads or ends wrongly moves the 0xFF00 fetch or shortens the GPIO window, so the bench measures both against the release cycle. A USB sequencer that is not cleared by a full reset leaks a stray 0xC090 strobe in the next cycle. Such a strobe does not match any expected event in the scoreboard.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam logic [15:0] BOOT_VEC  = 16'hFF00;
  localparam logic [15:0] ROM_BASE  = 16'hE000;
  localparam int          N_USB_REG = 2;
  localparam logic [15:0] USB_REG [N_USB_REG] = '{16'hC090, 16'hC0B0};

  // GPIO test-drive groups, inclusive bit ranges
  localparam int N_TST_GRP = 2;
  localparam int TST_LO [N_TST_GRP] = '{8, 19};
  localparam int TST_HI [N_TST_GRP] = '{15, 24};

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_DELAY,
    ST_FETCH0,
    ST_FETCH1,
    ST_RUN
  } boot_st_e;
endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int MIN_LOW = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic qual_o,
  output logic qual_rise_o
);
  localparam int CW = $clog2(MIN_LOW + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          pin_low;

  assign pin_low = ~sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_ni};
      if (!pin_low)                   cnt_q <= '0;
      else if (cnt_q != CW'(MIN_LOW)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign qual_o      = (cnt_q == CW'(MIN_LOW));
  assign qual_rise_o = pin_low && (cnt_q == CW'(MIN_LOW - 1));
endmodule

// File: rtl/boot_fsm.sv
module boot_fsm
  import boot_pkg::*;
#(
  parameter int BOOT_DLY = 40,
  parameter int GPIO_WIN = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rst_req_i,
  output logic        cpu_hold_o,
  output logic        fetch_valid_o,
  output logic [15:0] fetch_addr_o,
  output logic        test_win_o
);
  localparam int DW = $clog2(BOOT_DLY + 1);
  localparam int WW = $clog2(GPIO_WIN + 1);

  boot_st_e      st_q;
  logic [DW-1:0] dly_q;
  logic [WW-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_DELAY;
      dly_q <= '0;
      win_q <= '0;
    end else if (rst_req_i) begin
      st_q  <= ST_HOLD;
      dly_q <= '0;
      win_q <= '0;
    end else begin
      unique case (st_q)
        ST_HOLD:  st_q <= ST_DELAY;
        ST_DELAY: begin
          if (dly_q == DW'(BOOT_DLY - 1)) begin
            st_q  <= ST_FETCH0;
            dly_q <= '0;
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
        ST_FETCH0: st_q <= ST_FETCH1;
        ST_FETCH1: begin
          st_q  <= ST_RUN;
          win_q <= WW'(GPIO_WIN - 1);
        end
        ST_RUN: if (win_q != '0) win_q <= win_q - 1'b1;
        default: st_q <= ST_HOLD;
      endcase
    end
  end

  assign cpu_hold_o    = (st_q == ST_HOLD) || (st_q == ST_DELAY);
  assign fetch_valid_o = (st_q == ST_FETCH0) || (st_q == ST_FETCH1);
  assign fetch_addr_o  = (st_q == ST_FETCH0) ? BOOT_VEC :
                         (st_q == ST_FETCH1) ? ROM_BASE : 16'h0000;
  assign test_win_o    = (st_q == ST_FETCH1) || ((st_q == ST_RUN) && (win_q != '0));
endmodule

// File: rtl/usb_clr_seq.sv
module usb_clr_seq
  import boot_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        usb_reset_i,
  input  logic        full_i,
  output logic        clr_o,
  output logic [15:0] addr_o
);
  localparam int IW = $clog2(N_USB_REG + 1);

  // 0 = idle, k = clearing register k-1
  logic [IW-1:0] idx_q;
  logic [15:0]   addr_sel [N_USB_REG+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             idx_q <= '0;
    else if (full_i)                         idx_q <= '0;
    else if (idx_q == '0)                    idx_q <= usb_reset_i ? IW'(1) : '0;
    else if (idx_q == IW'(N_USB_REG))        idx_q <= '0;
    else                                     idx_q <= idx_q + 1'b1;
  end

  assign addr_sel[0] = 16'h0000;
  for (genvar g = 0; g < N_USB_REG; g++) begin : g_addr
    assign addr_sel[g+1] = USB_REG[g];
  end

  assign clr_o  = (idx_q != '0);
  assign addr_o = addr_sel[idx_q];
endmodule

// File: rtl/boot_reset_seq.sv
module boot_reset_seq
  import boot_pkg::*;
#(
  parameter int MIN_LOW_CYC  = 16,
  parameter int BOOT_DLY_CYC = 2400000,
  parameter int GPIO_WIN_CYC = 36000,
  parameter int GPIO_W       = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_pin_ni,
  input  logic              usb_reset_i,
  output logic              full_rst_o,
  output logic              usb_clr_o,
  output logic [15:0]       usb_clr_addr_o,
  output logic              cpu_hold_o,
  output logic              fetch_valid_o,
  output logic [15:0]       fetch_addr_o,
  output logic [GPIO_W-1:0] gpio_test_oe_o
);
  logic qual, qual_rise, full_now, test_win;
  logic por_q, full_q;

  rst_pin_filter #(.MIN_LOW(MIN_LOW_CYC)) u_filt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_ni      (rst_pin_ni),
    .qual_o      (qual),
    .qual_rise_o (qual_rise)
  );

  // power-on reset bypasses the qualifier
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_q  <= 1'b1;
      full_q <= 1'b1;
    end else begin
      por_q  <= 1'b0;
      full_q <= por_q | qual_rise;
    end
  end

  assign full_now   = por_q | qual_rise;
  assign full_rst_o = full_q;

  boot_fsm #(.BOOT_DLY(BOOT_DLY_CYC), .GPIO_WIN(GPIO_WIN_CYC)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rst_req_i     (qual | qual_rise),
    .cpu_hold_o    (cpu_hold_o),
    .fetch_valid_o (fetch_valid_o),
    .fetch_addr_o  (fetch_addr_o),
    .test_win_o    (test_win)
  );

  usb_clr_seq u_usb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .usb_reset_i (usb_reset_i),
    .full_i      (full_now),
    .clr_o       (usb_clr_o),
    .addr_o      (usb_clr_addr_o)
  );

  for (genvar i = 0; i < GPIO_W; i++) begin : g_oe
    localparam bit IN_GRP = ((i >= TST_LO[0]) && (i <= TST_HI[0])) ||
                            ((i >= TST_LO[1]) && (i <= TST_HI[1]));
    if (IN_GRP) begin : g_drv
      assign gpio_test_oe_o[i] = test_win;
    end else begin : g_off
      assign gpio_test_oe_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/boot_reset_seq_chk.sv
module boot_reset_seq_chk #(
  parameter int GPIO_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              full_rst_o,
  input logic              usb_clr_o,
  input logic [15:0]       usb_clr_addr_o,
  input logic              cpu_hold_o,
  input logic              fetch_valid_o,
  input logic [15:0]       fetch_addr_o,
  input logic [GPIO_W-1:0] gpio_test_oe_o
);
  localparam logic [GPIO_W-1:0] OE_MASK = GPIO_W'(32'h01F8_FF00);

  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_rst_o |-> (cpu_hold_o && (gpio_test_oe_o == '0)));                    // R2

  AST_FIRST_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fetch_valid_o) |-> (fetch_addr_o == 16'hFF00) && $past(cpu_hold_o)); // R3

  AST_FETCH_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_o && fetch_addr_o == 16'hFF00 && !full_rst_o)
      |=> (fetch_valid_o && fetch_addr_o == 16'hE000) || full_rst_o);          // R4

  AST_USB_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usb_clr_o |-> (usb_clr_addr_o == 16'hC090 || usb_clr_addr_o == 16'hC0B0)); // R5

  AST_USB_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (usb_clr_o && usb_clr_addr_o == 16'hC090)
      |=> (usb_clr_o && usb_clr_addr_o == 16'hC0B0) || full_rst_o);            // R5

  AST_FULL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_rst_o |-> !usb_clr_o);                                                // R6

  AST_OE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpio_test_oe_o != '0) |-> (gpio_test_oe_o == OE_MASK));                   // R7

  AST_OE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gpio_test_oe_o != '0) |-> (fetch_valid_o && fetch_addr_o == 16'hE000)); // R7
endmodule

bind boot_reset_seq boot_reset_seq_chk #(.GPIO_W(GPIO_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .full_rst_o     (full_rst_o),
  .usb_clr_o      (usb_clr_o),
  .usb_clr_addr_o (usb_clr_addr_o),
  .cpu_hold_o     (cpu_hold_o),
  .fetch_valid_o  (fetch_valid_o),
  .fetch_addr_o   (fetch_addr_o),
  .gpio_test_oe_o (gpio_test_oe_o)
);

// File: tb/tb_boot_reset_seq.sv
module tb_boot_reset_seq;
  localparam int BOOT = 40;
  localparam int WIN  = 12;
  localparam logic [31:0] MASK = 32'h01F8_FF00;

  typedef enum int {EV_FULL, EV_FETCH, EV_USB} ev_e;
  typedef struct {ev_e k; logic [15:0] a;} ev_t;

  logic clk = 1'b0, rst_ni = 1'b0, rst_pin_ni = 1'b1, usb_reset_i = 1'b0;
  logic full_rst_o, usb_clr_o, cpu_hold_o, fetch_valid_o;
  logic [15:0] usb_clr_addr_o, fetch_addr_o;
  logic [31:0] gpio_test_oe_o;

  ev_t q[$];
  int vec = 0, bad = 0, cyc = 0, rel_cyc = 0, exp_gap = 0, oe_run = 0;

  always #2 clk = ~clk;

  boot_reset_seq #(.MIN_LOW_CYC(16), .BOOT_DLY_CYC(BOOT), .GPIO_WIN_CYC(WIN), .GPIO_W(32)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .rst_pin_ni(rst_pin_ni), .usb_reset_i(usb_reset_i),
    .full_rst_o(full_rst_o), .usb_clr_o(usb_clr_o), .usb_clr_addr_o(usb_clr_addr_o),
    .cpu_hold_o(cpu_hold_o), .fetch_valid_o(fetch_valid_o), .fetch_addr_o(fetch_addr_o),
    .gpio_test_oe_o(gpio_test_oe_o)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(ev_e k, logic [15:0] a);
    ev_t e;
    e.k = k; e.a = a;
    q.push_back(e);
  endtask

  task automatic take(ev_e k, logic [15:0] a, string req);
    ev_t e;
    if (q.size() == 0) begin
      chk(1'b0, req, "unexpected event kind/addr", {int'(k), a}, -1);
    end else begin
      e = q.pop_front();
      chk(e.k == k && e.a == a, req, "event kind/addr", {int'(k), a}, {int'(e.k), e.a});
    end
  endtask

  task automatic push_boot();
    push(EV_FULL, 16'h0);
    push(EV_FETCH, 16'hFF00);
    push(EV_FETCH, 16'hE000);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  // monitor: samples 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_ni) begin
      cyc++;
      if (full_rst_o) take(EV_FULL, 16'h0, "R2");
      if (fetch_valid_o) begin
        take(EV_FETCH, fetch_addr_o, "R4");
        if (fetch_addr_o == 16'hFF00)
          chk(cyc - rel_cyc == exp_gap, "R3", "release-to-fetch cycles", cyc - rel_cyc, exp_gap);
      end
      if (usb_clr_o) take(EV_USB, usb_clr_addr_o, "R5");
      if (gpio_test_oe_o != '0) begin
        if (oe_run == 0) chk(gpio_test_oe_o == MASK, "R7", "oe value", gpio_test_oe_o, MASK);
        oe_run++;
      end else if (oe_run != 0) begin
        chk(oe_run == WIN, "R7", "oe window length", oe_run, WIN);
        oe_run = 0;
      end
    end
  end

  task automatic pin_pulse(int n);
    @(negedge clk) rst_pin_ni = 1'b0;
    repeat (n) @(negedge clk);
    rst_pin_ni = 1'b1;
    rel_cyc = cyc;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vec++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    // R8 reset state
    idle(3);
    chk(full_rst_o && cpu_hold_o && !fetch_valid_o && !usb_clr_o && gpio_test_oe_o == '0,
        "R8", "reset state", {full_rst_o, cpu_hold_o, fetch_valid_o, usb_clr_o}, 4'b1100);
    // power-on boot
    push_boot();
    exp_gap = BOOT;
    rel_cyc = cyc;
    rst_ni  = 1'b1;
    idle(BOOT + WIN + 20);
    chk(q.size() == 0, "R4", "power-on boot events outstanding", q.size(), 0);
    chk(!cpu_hold_o, "R4", "hold after boot", cpu_hold_o, 0);

    // R1: short pulses ignored
    pin_pulse(15);
    idle(30);
    chk(!cpu_hold_o && q.size() == 0, "R1", "15-cycle pulse ignored", cpu_hold_o, 0);
    pin_pulse(5);
    idle(30);
    chk(!cpu_hold_o, "R1", "5-cycle pulse ignored", cpu_hold_o, 0);
    @(negedge clk) rst_pin_ni = 1'b0;
    idle(15);
    rst_pin_ni = 1'b1;
    idle(1);
    rst_pin_ni = 1'b0;
    idle(15);
    rst_pin_ni = 1'b1;
    idle(30);
    chk(!cpu_hold_o, "R1", "split pulse counter restart", cpu_hold_o, 0);

    // R2/R3: minimum qualified pulse
    push_boot();
    exp_gap = BOOT + 4;
    pin_pulse(16);
    idle(2);
    chk(cpu_hold_o, "R2", "hold after qualified pulse", cpu_hold_o, 1);
    idle(BOOT + WIN + 20);
    chk(q.size() == 0, "R2", "16-cycle boot events outstanding", q.size(), 0);

    // long pulse
    push_boot();
    exp_gap = BOOT + 4;
    pin_pulse(60);
    idle(BOOT + WIN + 20);
    chk(q.size() == 0, "R3", "60-cycle boot events outstanding", q.size(), 0);

    // R5: USB reset alone
    push(EV_USB, 16'hC090);
    push(EV_USB, 16'hC0B0);
    @(negedge clk) usb_reset_i = 1'b1;
    @(negedge clk) usb_reset_i = 1'b0;
    idle(6);
    chk(!cpu_hold_o && !full_rst_o && gpio_test_oe_o == '0 && q.size() == 0,
        "R5", "usb reset scope", {cpu_hold_o, full_rst_o, 8'(q.size())}, 0);

    // R6: USB reset in the qualifying cycle
    push_boot();
    exp_gap = BOOT + 4;
    @(negedge clk) rst_pin_ni = 1'b0;
    idle(17);
    usb_reset_i = 1'b1;
    @(negedge clk) usb_reset_i = 1'b0;
    idle(1);
    rst_pin_ni = 1'b1;
    rel_cyc = cyc;
    idle(BOOT + WIN + 20);
    chk(q.size() == 0, "R6", "full reset wins over usb", q.size(), 0);

    summary();
    $finish;
  end
endmodule